// File: doc/BRIEF.md
# Periodic Wakeup and Reset Controller

This block paces a low-power system from a slow tick that arrives as a one-cycle enable on the system clock. A first counter measures a programmable number of ticks, from 1 to 63. At the end of each interval it produces a wakeup event. That event raises a sticky wakeup interrupt, which stays high until a separate acknowledge input clears it. A second counter counts wakeup events. After a programmable number of events, from 1 to 63, it issues a one-cycle periodic reset pulse. A sticky flag records that this pulse has occurred.

Software reaches the block through two byte-wide registers, each with its own write strobe. The wake byte holds the wakeup interval. The control/status byte holds the periodic-reset interval, the reset flag and an acknowledge bit. Writing zero to an interval field turns that function off. An interlock refuses any write that would turn both functions off, so at least one of them always runs.

There are two reset inputs. Power-on reset clears everything. General reset restores the intervals and counters but keeps the reset flag, so software can tell after a restart that the periodic reset caused it.

Top module: `wakeup_reset_ctrl`

## Requirements
- R1: After power-on reset, both read bytes return 8'h3F (both intervals equal 63, flag clear), and wake_irq and per_rst are low.
- R2: With wake field value N (1..63), a wakeup event occurs on every Nth tick. For a nonzero field, the event sets wake_irq within two clock cycles of that tick. The wake field is bits 5:0 of the wake byte, and bits 7:6 of that byte read 0.
- R3: wake_irq stays high until wake_ack is sampled high, and it falls on the next cycle. A new wakeup event in the same cycle as the acknowledge keeps it high.
- R4: With reset field value M (1..63), per_rst is a one-cycle pulse on every Mth wakeup event. It fires in the same cycle that wake_irq rises. Wakeup events keep counting even when the wake field is zero.
- R5: Writing a field value that differs from the one held restarts only that field's counter from zero. Writing the value already held leaves all timing unchanged.
- R6: Writing zero to the wake field does two things. It suppresses wake_irq, and it makes the wake interval 63 ticks. The write is refused when the reset field is zero, and a refused write leaves the field and all timing unchanged.
- R7: Writing zero to the reset field stops per_rst. The write is refused when the wake field is zero. If both fields are written to zero in the same cycle, the reset-field write is accepted and the wake-field write is refused.
- R8: The control/status byte has the flag in bit 7, the acknowledge in bit 6 and the reset field in bits 5:0. The flag sets after a per_rst pulse. A write with bit 6 = 1 clears the flag, and a write with bit 6 = 0 leaves it. Bit 6 reads 0, and writing bit 7 never changes the flag.
- R9: General reset restores both fields to 63 and keeps the flag. Power-on reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_por | input | 1 | Synchronous power-on reset, active high |
| rst_gen | input | 1 | Synchronous general reset, active high; keeps the flag |
| tick | input | 1 | One-cycle wakeup clock tick |
| wr_ctl | input | 1 | Write strobe for the control/status byte |
| wr_wake | input | 1 | Write strobe for the wake byte |
| wdata | input | 8 | Write data for either byte |
| wake_ack | input | 1 | Clears the pending wakeup interrupt |
| rd_ctl | output | 8 | Control/status byte: flag, 0, reset field |
| rd_wake | output | 8 | Wake byte: zero-extended wake field |
| wake_irq | output | 1 | Sticky wakeup interrupt |
| per_rst | output | 1 | One-cycle periodic reset pulse |

## Verification
The bench builds the block with its default 6-bit field width. At that width the extreme interval of 63 ticks is reachable: with the wake field zero and a reset interval of 3, the first periodic reset needs 189 ticks. The interlock corners are covered at the same width, including the same-cycle double zero write and unchanged-value rewrites in the middle of an interval.

// File: rtl/wkr_pkg.sv
package wkr_pkg;
  localparam int BYTE_W   = 8;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
endpackage

// File: rtl/wkr_interval_cnt.sv
module wkr_interval_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         en,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic         fire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (adv) begin
        if (cnt == lim - W'(1)) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

  // R2: the running count stays inside the programmed interval
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < lim));

  // R4: an interval end only follows an advance
  p_fire_adv_r4: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(adv));
endmodule

// File: rtl/wkr_regs.sv
module wkr_regs #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_por,
  input  logic         rst_gen,
  input  logic         wr_ctl,
  input  logic         wr_wake,
  input  logic [W-1:0] wfield,
  input  logic         ack_bit,
  input  logic         set_flag,
  output logic [W-1:0] wut,
  output logic [W-1:0] prst,
  output logic         flag,
  output logic         restart_w,
  output logic         restart_r
);
  logic         rst_any;
  logic [W-1:0] prst_nxt;

  assign rst_any = rst_por | rst_gen;

  // reset-field write wins the interlock when both land together
  assign restart_r = wr_ctl && (wfield != prst) && ((wfield != '0) || (wut != '0));
  assign prst_nxt  = restart_r ? wfield : prst;
  assign restart_w = wr_wake && (wfield != wut) && ((wfield != '0) || (prst_nxt != '0));

  always_ff @(posedge clk) begin
    if (rst_any) begin
      wut  <= '1;
      prst <= '1;
    end else begin
      prst <= prst_nxt;
      if (restart_w) wut <= wfield;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_por)                flag <= 1'b0;
    else if (set_flag)          flag <= 1'b1;
    else if (wr_ctl && ack_bit) flag <= 1'b0;
  end

  // R6: the two fields are never both zero
  p_interlock_r6: assert property (@(posedge clk) disable iff (rst_any)
    (wut != '0) || (prst != '0));

  // R6: a refused wake zero write leaves the field
  p_wut_refuse_r6: assert property (@(posedge clk) disable iff (rst_any)
    (wr_wake && (wfield == '0) && (prst == '0)) |=> $stable(wut));

  // R7: a refused reset zero write leaves the field
  p_prst_refuse_r7: assert property (@(posedge clk) disable iff (rst_any)
    (wr_ctl && (wfield == '0) && (wut == '0)) |=> $stable(prst));

  // R8: acknowledge clears the flag unless a new pulse sets it
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst_por)
    (wr_ctl && ack_bit && !set_flag) |=> !flag);

  // R9: power-on reset clears the flag
  p_flag_por_r9: assert property (@(posedge clk)
    rst_por |=> !flag);

  // R9: general reset keeps the flag
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (rst_por)
    (flag && rst_gen) |=> flag);
endmodule

// File: rtl/wakeup_reset_ctrl.sv
module wakeup_reset_ctrl #(
  parameter int W = 6
) (
  input  logic                      clk,
  input  logic                      rst_por,
  input  logic                      rst_gen,
  input  logic                      tick,
  input  logic                      wr_ctl,
  input  logic                      wr_wake,
  input  logic [wkr_pkg::BYTE_W-1:0] wdata,
  input  logic                      wake_ack,
  output logic [wkr_pkg::BYTE_W-1:0] rd_ctl,
  output logic [wkr_pkg::BYTE_W-1:0] rd_wake,
  output logic                      wake_irq,
  output logic                      per_rst
);
  localparam int BW = wkr_pkg::BYTE_W;

  logic         rst_any;
  logic [W-1:0] wut, prst, lim_w;
  logic         flag, restart_w, restart_r, wake_evt, wake_on, rst_on;

  assign rst_any = rst_por | rst_gen;
  assign wake_on = (wut != '0);
  assign rst_on  = (prst != '0);
  assign lim_w   = wake_on ? wut : '1;

  wkr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_por(rst_por), .rst_gen(rst_gen),
    .wr_ctl(wr_ctl), .wr_wake(wr_wake), .wfield(wdata[W-1:0]),
    .ack_bit(wdata[wkr_pkg::ACK_BIT]), .set_flag(per_rst),
    .wut(wut), .prst(prst), .flag(flag),
    .restart_w(restart_w), .restart_r(restart_r)
  );

  wkr_interval_cnt #(.W(W)) u_wake_cnt (
    .clk(clk), .rst(rst_any), .restart(restart_w), .en(1'b1),
    .adv(tick), .lim(lim_w), .fire(wake_evt)
  );

  wkr_interval_cnt #(.W(W)) u_rst_cnt (
    .clk(clk), .rst(rst_any), .restart(restart_r), .en(rst_on),
    .adv(wake_evt), .lim(prst), .fire(per_rst)
  );

  always_ff @(posedge clk) begin
    if (rst_any)                  wake_irq <= 1'b0;
    else if (wake_evt && wake_on) wake_irq <= 1'b1;
    else if (wake_ack)            wake_irq <= 1'b0;
  end

  assign rd_ctl  = {flag, (BW-1)'(prst)};
  assign rd_wake = BW'(wut);

  // R3: pending interrupt holds until acknowledged
  p_irq_hold_r3: assert property (@(posedge clk) disable iff (rst_any)
    (wake_irq && !wake_ack) |=> wake_irq);

  // R3: acknowledge without a new event drops the interrupt
  p_irq_ack_r3: assert property (@(posedge clk) disable iff (rst_any)
    (wake_ack && !wake_evt) |=> !wake_irq);

  // R7: no periodic reset while the reset field is zero
  p_off_no_rst_r7: assert property (@(posedge clk) disable iff (rst_any)
    !rst_on |=> !per_rst);

  // R8: writing the flag bit alone never sets the flag
  p_flag_wr_ignored_r8: assert property (@(posedge clk) disable iff (rst_por)
    (wr_ctl && wdata[wkr_pkg::FLAG_BIT] && !wdata[wkr_pkg::ACK_BIT] && !flag && !per_rst) |=> !flag);
endmodule

// File: tb/test_wakeup_reset_ctrl.sv
`timescale 1ns/1ps
module test_wakeup_reset_ctrl;
  logic       clk = 1'b0;
  logic       rst_por = 1'b1, rst_gen = 1'b0, tick = 1'b0;
  logic       wr_ctl = 1'b0, wr_wake = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       wake_ack;
  logic [7:0] rd_ctl, rd_wake;
  logic       wake_irq, per_rst;

  always #2.5 clk = ~clk;

  wakeup_reset_ctrl #(.W(6)) i_wakeup_reset_ctrl (
    .clk(clk), .rst_por(rst_por), .rst_gen(rst_gen), .tick(tick),
    .wr_ctl(wr_ctl), .wr_wake(wr_wake), .wdata(wdata), .wake_ack(wake_ack),
    .rd_ctl(rd_ctl), .rd_wake(rd_wake), .wake_irq(wake_irq), .per_rst(per_rst)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct { byte kind; int tno; } ev_t;
  ev_t q[$];

  int  wut_m, prst_m, wc, rc, tick_no;
  bit  auto_ack = 1'b1, man_ack = 1'b0, ack_auto_q = 1'b0, irq_prev = 1'b0;
  assign wake_ack = auto_ack ? ack_auto_q : man_ack;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    wut_m = 63; prst_m = 63; wc = 0; rc = 0;
  endtask

  // driver: issues one tick and pushes the expected events
  task automatic do_tick();
    int lim;
    @(negedge clk);
    tick = 1'b1;
    tick_no++;
    wc++;
    lim = (wut_m == 0) ? 63 : wut_m;
    if (wc == lim) begin
      wc = 0;
      if (wut_m != 0) q.push_back('{kind: "W", tno: tick_no});
      if (prst_m != 0) begin
        rc++;
        if (rc == prst_m) begin
          rc = 0;
          q.push_back('{kind: "R", tno: tick_no});
        end
      end
    end
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic write_wake(int v);
    @(negedge clk);
    wr_wake = 1'b1; wdata = 8'(v);
    if (v != wut_m && (v != 0 || prst_m != 0)) begin wut_m = v; wc = 0; end
    @(negedge clk);
    wr_wake = 1'b0;
  endtask

  task automatic write_ctl(int v, bit ack, bit b7);
    @(negedge clk);
    wr_ctl = 1'b1; wdata = {b7, ack, 6'(v)};
    if (v != prst_m && (v != 0 || wut_m != 0)) begin prst_m = v; rc = 0; end
    @(negedge clk);
    wr_ctl = 1'b0;
  endtask

  task automatic write_both_zero();
    @(negedge clk);
    wr_ctl = 1'b1; wr_wake = 1'b1; wdata = 8'h00;
    if (prst_m != 0 && wut_m != 0) begin prst_m = 0; rc = 0; end
    if (wut_m != 0 && prst_m != 0) begin wut_m = 0; wc = 0; end
    @(negedge clk);
    wr_ctl = 1'b0; wr_wake = 1'b0;
  endtask

  task automatic pop_check(byte kind);
    ev_t e;
    string req;
    req = (kind == "W") ? "R2" : "R4";
    if (q.size() == 0) begin
      check(1'b0, req, "unexpected event at tick", tick_no, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind, req, "event kind", int'(kind), int'(e.kind));
      check(e.tno == tick_no, req, "event tick", tick_no, e.tno);
    end
  endtask

  // monitor: compares produced events against the scoreboard queue
  always @(negedge clk) begin
    if (!rst_por && !rst_gen) begin
      if (wake_irq && !irq_prev) pop_check("W");
      if (per_rst) pop_check("R");
    end
    irq_prev   = wake_irq;
    ack_auto_q = wake_irq;
  end

  task automatic settle();
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2", "pending expected events", q.size(), 0);
  endtask

  initial begin
    #(5.0 * 20000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    tick_no = 0;
    repeat (4) @(negedge clk);
    rst_por = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_ctl == 8'h3F, "R1", "rd_ctl after reset", rd_ctl, 8'h3F);
    check(rd_wake == 8'h3F, "R1", "rd_wake after reset", rd_wake, 8'h3F);
    check(!wake_irq && !per_rst, "R1", "outputs after reset", {wake_irq, per_rst}, 0);

    // R2 / R4 basic intervals
    write_wake(3);
    write_ctl(2, 1'b0, 1'b0);
    ticks(12);
    settle();
    check(rd_ctl[7] == 1'b1, "R8", "flag after periodic reset", rd_ctl[7], 1);

    // R8 flag acknowledge
    write_ctl(2, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_ctl[7] == 1'b1, "R8", "flag kept by ack=0", rd_ctl[7], 1);
    write_ctl(2, 1'b1, 1'b0);
    @(negedge clk);
    check(rd_ctl == 8'h02, "R8", "flag cleared, ack bit reads 0", rd_ctl, 8'h02);
    write_ctl(2, 1'b0, 1'b1);
    @(negedge clk);
    check(rd_ctl == 8'h02, "R8", "flag bit write ignored", rd_ctl, 8'h02);

    // R3 sticky interrupt
    auto_ack = 1'b0;
    ticks(3);
    repeat (8) @(negedge clk);
    check(wake_irq == 1'b1, "R3", "irq held without ack", wake_irq, 1);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    @(negedge clk);
    check(wake_irq == 1'b0, "R3", "irq cleared by ack", wake_irq, 0);
    auto_ack = 1'b1;
    settle();

    // R5 rewrite of same value vs new value
    write_wake(5);
    ticks(3);
    write_wake(5);
    ticks(2);
    ticks(2);
    write_wake(4);
    ticks(4);
    settle();
    check(rd_wake == 8'h04, "R5", "wake field", rd_wake, 4);

    // R7 / R6 disable and interlock
    write_ctl(0, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_ctl[5:0] == 6'd0, "R7", "reset field cleared", rd_ctl[5:0], 0);
    write_wake(0);
    @(negedge clk);
    check(rd_wake == 8'h04, "R6", "wake zero refused", rd_wake, 4);
    ticks(8);
    settle();
    write_ctl(3, 1'b0, 1'b0);
    write_wake(0);
    @(negedge clk);
    check(rd_wake == 8'h00, "R6", "wake zero accepted", rd_wake, 0);
    ticks(189);
    settle();
    check(wake_irq == 1'b0, "R6", "irq stays off with wake disabled", wake_irq, 0);
    write_ctl(0, 1'b1, 1'b0);
    @(negedge clk);
    check(rd_ctl == 8'h03, "R7", "reset zero refused, flag acked", rd_ctl, 8'h03);

    // R7 same-cycle double zero write
    write_wake(2);
    write_ctl(2, 1'b0, 1'b0);
    write_both_zero();
    @(negedge clk);
    check(rd_ctl[5:0] == 6'd0, "R7", "reset field wins", rd_ctl[5:0], 0);
    check(rd_wake == 8'h02, "R7", "wake field kept", rd_wake, 2);

    // R9 reset behaviour of the flag
    write_ctl(1, 1'b0, 1'b0);
    ticks(2);
    settle();
    @(negedge clk);
    rst_gen = 1'b1;
    repeat (3) @(negedge clk);
    rst_gen = 1'b0;
    model_reset();
    @(negedge clk);
    check(rd_ctl == 8'hBF, "R9", "general reset keeps flag", rd_ctl, 8'hBF);
    check(rd_wake == 8'h3F, "R9", "general reset restores wake", rd_wake, 8'h3F);
    rst_por = 1'b1;
    repeat (3) @(negedge clk);
    rst_por = 1'b0;
    @(negedge clk);
    check(rd_ctl == 8'h3F, "R9", "power-on reset clears flag", rd_ctl, 8'h3F);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule